// File: doc/BRIEF.md
# Game Port Axis and Button Status Emulator

This block stands in for a legacy joystick port that serves two sticks, each with two axes and two buttons. It drives one 8-bit status word for software to read. A write strobe starts a measurement on all four axes together. Each axis bit then stays high for a time that follows from that axis's position input, and then drops. Software polls the word and times each bit to recover the stick position. No capacitor circuit is modelled. The pulse length is the position count multiplied by the period of a programmable tick.

The raw button inputs are active high, where 1 means pressed. Each one passes through a two-flop synchroniser and then a consecutive-sample filter. The result is shown inverted, so a pressed button reads 0. A mode input selects analog or digital operation. The button bits are valid in both modes. In digital mode the axis bits are held low and writes do not start a measurement. The status word comes straight from internal registers, so a read has no side effects and needs no strobe. All pins are plain control and status pins, and the block has no streamed data path.

Top module: `gameport_timer`

## Requirements
- R1: Status bit positions: bit 0 is stick A x-axis, bit 1 is A y-axis, bit 2 is B x-axis, bit 3 is B y-axis, bit 4 is A button 1, bit 5 is A button 2, bit 6 is B button 1, bit 7 is B button 2. The position input slice i (bits i*8+7..i*8) belongs to axis bit i. The press input bit j belongs to status bit 4+j.
- R2: After reset the status word is 8'hF0.
- R3: A write (wr_en high at a clock edge) in analog mode sets every axis bit whose position is non-zero to 1 from the cycle after the write. An axis whose position is zero stays 0.
- R4: An axis bit stays high for exactly position × (tick_div + 1) clock cycles after the write, and then returns to 0.
- R5: A write during a running measurement restarts all four axes and the tick prescaler from zero, using the positions present at the new write.
- R6: An axis bit never rises except on the cycle after a write in analog mode.
- R7: While analog_mode is 0, every axis bit reads 0 from the cycle after the mode drops. A running measurement is abandoned, and writes start nothing.
- R8: A button bit reads 0 while its debounced press input is 1, and reads 1 when it is 0.
- R9: A change of a press input reaches its status bit exactly DEB_SAMPLES + 2 cycles after the input is sampled. This covers two synchroniser cycles and DEB_SAMPLES equal samples. A pulse shorter than DEB_SAMPLES cycles never reaches the status bit.
- R10: Button filtering and reporting work the same in digital and analog mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe that starts a measurement |
| analog_mode | input | 1 | 1 selects analog mode, 0 selects digital mode |
| tick_div | input | DIV_W | Tick period is tick_div + 1 clock cycles |
| axis_pos | input | 4*POS_W | Four axis position counts, axis i in slice i |
| btn_press | input | 4 | Raw button inputs, 1 = pressed |
| status | output | 8 | Status word |

## Verification
The bench measures each axis pulse with positions of zero, one and large values. A design that is off by one in its prescaler or its countdown would give pulses one tick too long or too short. The bench also issues a second write during a running measurement, because a design that ignores restarts would keep the old pulse length. It drops the mode in the middle of a pulse and writes while in digital mode, to catch axis bits that stay high or start when they should not. On the button side, it times the exact cycle a press appears, and it feeds a pulse one sample short of the filter length. A filter that counts one sample too few would let that pulse through.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int AXIS_COUNT = 4;
  localparam int BUTTON_COUNT = 4;
  localparam int STATUS_W = AXIS_COUNT + BUTTON_COUNT;
  localparam int BTN_BASE = AXIS_COUNT;

  typedef enum logic [1:0] {
    AX_A_X = 2'd0,
    AX_A_Y = 2'd1,
    AX_B_X = 2'd2,
    AX_B_Y = 2'd3
  } axis_sel_e;
endpackage

// File: rtl/gp_prescaler.sv
module gp_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= div);
  assign tick = wrap && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gp_axis_oneshot.sv
module gp_axis_oneshot #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             tick,
  input  logic [POS_W-1:0] pos,
  output logic             active
);
  logic [POS_W-1:0] remain_q;
  logic             active_q;

  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      remain_q <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      remain_q <= pos;
      active_q <= (pos != '0);
    end else if (tick && active_q) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q <= POS_W'(1)) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gp_button_filter.sv
module gp_button_filter #(
  parameter int SAMPLES     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];
  assign level  = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (synced != level_q) begin
      if (run_q == CW'(SAMPLES - 1)) begin
        level_q <= synced;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/gameport_timer.sv
module gameport_timer #(
  parameter int POS_W       = 8,
  parameter int DIV_W       = 8,
  parameter int DEB_SAMPLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic                                 analog_mode,
  input  logic [DIV_W-1:0]                     tick_div,
  input  logic [gp_pkg::AXIS_COUNT*POS_W-1:0]  axis_pos,
  input  logic [gp_pkg::BUTTON_COUNT-1:0]      btn_press,
  output logic [gp_pkg::STATUS_W-1:0]          status
);
  import gp_pkg::*;

  logic                    tick;
  logic                    start;
  logic [AXIS_COUNT-1:0]   axis_active;
  logic [BUTTON_COUNT-1:0] pressed;

  assign start = wr_en && analog_mode;

  gp_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .div(tick_div), .tick(tick)
  );

  for (genvar a = 0; a < AXIS_COUNT; a++) begin : g_axis
    gp_axis_oneshot #(.POS_W(POS_W)) u_shot (
      .clk(clk), .rst_n(rst_n), .enable(analog_mode), .start(start),
      .tick(tick), .pos(axis_pos[a*POS_W +: POS_W]), .active(axis_active[a])
    );
    assign status[a] = axis_active[a];
  end

  for (genvar b = 0; b < BUTTON_COUNT; b++) begin : g_btn
    gp_button_filter #(.SAMPLES(DEB_SAMPLES), .SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(btn_press[b]), .level(pressed[b])
    );
    assign status[BTN_BASE + b] = ~pressed[b];
  end
endmodule

// File: rtl/gp_port_checker.sv
module gp_port_checker #(
  parameter int POS_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 analog_mode,
  input logic [4*POS_W-1:0]   axis_pos,
  input logic [3:0]           btn_press,
  input logic [7:0]           status
);
  assert_reset_word_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> status == 8'hF0);

  assert_digital_axes_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(analog_mode) |-> status[3:0] == 4'h0);

  for (genvar i = 0; i < 4; i++) begin : g_ax
    assert_start_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && analog_mode) |=> status[i] == ($past(axis_pos[i*POS_W +: POS_W]) != '0));
    assert_rise_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(wr_en && analog_mode));
  end

  for (genvar j = 0; j < 4; j++) begin : g_bt
    assert_press_filtered_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[4+j]) |-> $past(btn_press[j], 3));
    assert_release_filtered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[4+j]) |-> !$past(btn_press[j], 3));
  end
endmodule

bind gameport_timer gp_port_checker #(.POS_W(POS_W)) u_port_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .analog_mode(analog_mode),
  .axis_pos(axis_pos), .btn_press(btn_press), .status(status)
);

// File: tb/gameport_timer_bench.sv
module gameport_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        analog_mode = 1'b0;
  logic [7:0]  tick_div = 8'd0;
  logic [31:0] axis_pos = '0;
  logic [3:0]  btn_press = '0;
  logic [7:0]  status;

  int errors = 0;
  int checks = 0;
  int hicnt[4];

  int cd[4];
  int sh1[4], sh2[4], stab[4], run[4];
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  gameport_timer u_gameport_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .analog_mode(analog_mode),
    .tick_div(tick_div), .axis_pos(axis_pos), .btn_press(btn_press), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: countdown per axis in clock cycles, delay line plus run count per button
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) begin
        cd[i] = 0; sh1[i] = 0; sh2[i] = 0; stab[i] = 0; run[i] = 0;
      end else begin
        if (!analog_mode) cd[i] = 0;
        else if (wr_en) cd[i] = int'(axis_pos[i*8 +: 8]) * (int'(tick_div) + 1);
        else if (cd[i] > 0) cd[i] = cd[i] - 1;
        if (sh2[i] != stab[i]) begin
          run[i] = run[i] + 1;
          if (run[i] == N) begin stab[i] = sh2[i]; run[i] = 0; end
        end else run[i] = 0;
        sh2[i] = sh1[i];
        sh1[i] = int'(btn_press[i]);
      end
    end
    for (int i = 0; i < 4; i++) begin
      model[i]   = (cd[i] > 0);
      model[4+i] = (stab[i] == 0);
    end
  end

  // R1: whole word compared with the model every cycle, layout as stated
  always @(negedge clk) begin
    if (rst_n) check(status == model, "R1 lockstep word", status, model);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write();
    wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(input int n);
    for (int i = 0; i < 4; i++) hicnt[i] = 0;
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < 4; i++) if (status[i]) hicnt[i]++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'hF0, "R2 reset word", status, 8'hF0);

    // R3/R4: pulse lengths, div=2 -> 3 cycles per tick
    analog_mode = 1'b1; tick_div = 8'd2;
    axis_pos = {8'd10, 8'd1, 8'd0, 8'd5};
    cyc(2);
    do_write();
    check(status[3:0] == 4'b1101, "R3 axes high after write", status[3:0], 4'b1101);
    measure(60);
    check(hicnt[0] == 15, "R4 A x length", hicnt[0], 15);
    check(hicnt[1] == 0,  "R3 zero position stays low", hicnt[1], 0);
    check(hicnt[2] == 3,  "R4 B x length", hicnt[2], 3);
    check(hicnt[3] == 30, "R4 B y length", hicnt[3], 30);

    // R4 with div=0 and a maximal position
    tick_div = 8'd0; axis_pos = {8'd0, 8'd0, 8'd0, 8'd255};
    do_write();
    measure(300);
    check(hicnt[0] == 255, "R4 div0 max position", hicnt[0], 255);

    // R5: restart mid-run
    tick_div = 8'd2; axis_pos = {8'd10, 8'd0, 8'd0, 8'd5};
    do_write();
    cyc(7);
    axis_pos = {8'd10, 8'd0, 8'd0, 8'd2};
    do_write();
    measure(60);
    check(hicnt[0] == 6,  "R5 restart uses new position", hicnt[0], 6);
    check(hicnt[3] == 30, "R5 restart full length", hicnt[3], 30);

    // R6: no write, no rise
    measure(40);
    check(hicnt[0] + hicnt[1] + hicnt[2] + hicnt[3] == 0, "R6 idle axes stay low",
          hicnt[0] + hicnt[1] + hicnt[2] + hicnt[3], 0);

    // R7: digital mode ignores write and aborts a run
    analog_mode = 1'b0; axis_pos = {8'd9, 8'd9, 8'd9, 8'd9};
    cyc(1);
    do_write();
    measure(10);
    check(hicnt[0] + hicnt[3] == 0, "R7 write ignored in digital", hicnt[0] + hicnt[3], 0);
    analog_mode = 1'b1;
    cyc(1);
    do_write();
    cyc(4);
    analog_mode = 1'b0;
    @(negedge clk);
    check(status[3:0] == 4'h0, "R7 run aborted", status[3:0], 0);

    // R8/R9: press A button 1, exact latency
    btn_press[0] = 1'b1;
    cyc(N + 1);
    check(status[4] == 1'b1, "R9 not yet changed", status[4], 1);
    @(negedge clk);
    check(status[4] == 1'b0, "R8 pressed reads 0", status[4], 0);
    btn_press[0] = 1'b0;
    cyc(N + 2);
    check(status[4] == 1'b1, "R8 released reads 1", status[4], 1);

    // R9: glitch one sample short on B button 2
    btn_press[3] = 1'b1;
    cyc(N - 1);
    btn_press[3] = 1'b0;
    for (int k = 0; k < N + 4; k++) begin
      if (!status[7]) check(1'b0, "R9 short pulse leaked", status[7], 1);
      @(negedge clk);
    end
    check(status[7] == 1'b1, "R9 short pulse rejected", status[7], 1);

    // R10: buttons in analog mode too
    analog_mode = 1'b1;
    btn_press[2] = 1'b1;
    cyc(N + 2);
    check(status[6] == 1'b0, "R10 press in analog mode", status[6], 0);
    btn_press[2] = 1'b0;
    cyc(N + 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule